// File: doc/BRIEF.md
# In-band auto-negotiation configuration word handler

This block sits beside a gigabit PCS and handles the 16-bit configuration word exchanged in band during auto-negotiation. It builds the word to transmit and interprets the words coming back from the link partner. It supports two protocols. In the asymmetric SGMII exchange, one end (the PHY side) dictates link, duplex and speed, and the other end (the MAC side) only acknowledges. In the symmetric 1000BASE-X exchange, each end sends an advertisement word taken from a register.

A control register selects the protocol and the role, and it holds the local link parameters. Its reset value selects MAC-side SGMII, so the port works without any programming. Received words pass through a consistency filter before they are accepted. After acceptance the block sets the acknowledge bit in its own word. Negotiation completes when the partner acknowledges in turn. On the MAC side of SGMII, the block can also let the PCS speed follow the speed the partner negotiated.

Top module: `icw_top`

## Requirements
- R1: After reset the control register holds 0x004 (MAC-side SGMII), the advertisement register holds 0x0020, the transmitted word is 0x0001, and both the completion flag and the link output are 0.
- R2: In PHY-side SGMII the transmitted word is {link, ack, 0, duplex, speed[1:0], nine zeros, 1}, with link at bit 15, ack at bit 14, duplex at bit 12 and speed at bits 11:10. The speed code is 00 for 10 Mb/s, 01 for 100 Mb/s and 10 for 1000 Mb/s.
- R3: In PHY-side SGMII, link, duplex and speed come from the hw_link_i, hw_duplex_i and hw_speed_i pins when control bit 0 is 1. When control bit 0 is 0 they come from control bit 4 (link), bit 5 (duplex) and bits 7:6 (speed).
- R4: In MAC-side SGMII the transmitted word is 0x0001 before a partner word is accepted and 0x4001 after it is accepted.
- R5: In MAC-side SGMII, once negotiation completes, link_o and duplex_o take bits 15 and 12 of the accepted word. speed_o takes bits 11:10 of the accepted word when control bit 8 (speed follow) is 1, and control bits 7:6 when bit 8 is 0.
- R6: In 1000BASE-X, speed_o is always 10 (1000 Mb/s) whatever the speed bits and the speed-follow bit say. duplex_o is 1 only when negotiation is complete and bit 5 is set in both the advertisement and the accepted word.
- R7: In 1000BASE-X the transmitted word is the advertisement register with bit 14 replaced by the acknowledge state. The register can be written with any value, for example 0x01A0.
- R8: Control bit 2 selects SGMII when 1 and 1000BASE-X when 0. Control bit 3 selects the PHY side when 1. Writing 0x018 therefore gives 1000BASE-X.
- R9: A received word is accepted after three consecutive valid words that are equal with bit 14 ignored. From then on bit 14 of the transmitted word is 1.
- R10: After acceptance, negotiation completes (an_done_o = 1) once three consecutive received words match the accepted word and carry bit 14 set.
- R11: In SGMII a word is valid only when bit 0 is 1 and bits 11:10 are not 11. An invalid word resets the count of consecutive matches.
- R12: After acceptance, a valid-strobed word that is invalid or differs from the accepted word (bit 14 ignored) restarts negotiation. This clears the acknowledge bit, an_done_o and link_o.
- R13: When timeout_i is nonzero, timeout_i consecutive cycles without rx_valid_i restart negotiation. A timeout_i of 0 disables the timeout.
- R14: Any write to the control register restarts negotiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control register write data |
| adv_we_i | input | 1 | Advertisement register write strobe |
| adv_wdata_i | input | 16 | Advertisement register write data |
| hw_link_i | input | 1 | PHY-side link status pin |
| hw_duplex_i | input | 1 | PHY-side duplex pin |
| hw_speed_i | input | 2 | PHY-side speed pins |
| rx_word_i | input | 16 | Received configuration word |
| rx_valid_i | input | 1 | Received word strobe |
| timeout_i | input | 16 | Loss-of-word timeout in cycles, 0 disables it |
| tx_word_o | output | 16 | Configuration word to transmit |
| link_o | output | 1 | Resolved link |
| speed_o | output | 2 | Resolved speed code |
| duplex_o | output | 1 | Resolved duplex, 1 means full |
| an_done_o | output | 1 | Auto-negotiation complete |

## Verification
Directed sequences on the MAC side use partner words that repeat exactly, words broken by a reserved speed code or a cleared bit 0, and words that change after acceptance. Together these separate the acceptance count, the validity check and the restart path. Idle gaps one cycle shorter than the timeout and exactly as long as it show where the timeout boundary lies. Random register fields and pin values on the PHY side show whether the word is taken from the register or from the pins. Random advertisement and partner words in 1000BASE-X show that the speed stays fixed, that duplex is the AND of both sides, and that the acknowledge bit replaces bit 14 correctly.

// File: rtl/icw_pkg.sv
package icw_pkg;
  localparam int WORD_W  = 16;
  localparam int ACK_BIT = 14;
  localparam int CTRL_W  = 9;

  typedef enum logic [1:0] {ST_HUNT, ST_ACKING, ST_DONE} neg_state_e;

  typedef struct packed {
    logic       spd_follow;
    logic [1:0] speed;
    logic       duplex;
    logic       link;
    logic       phy_side;
    logic       sgmii;
    logic       rsvd;
    logic       hw_sel;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RST = 9'h004;
  localparam logic [WORD_W-1:0] ADV_RST  = 16'h0020;
  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_BIT;

  function automatic logic word_ok(input logic [WORD_W-1:0] w, input logic sgmii);
    if (!sgmii) return 1'b1;
    return w[0] && (w[11:10] != 2'b11);
  endfunction
endpackage

// File: rtl/icw_rx_track.sv
module icw_rx_track
  import icw_pkg::*;
#(
  parameter int MATCH_N = 3,
  parameter int ACK_N   = 3,
  parameter int TMO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              sgmii_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output neg_state_e        state_o,
  output logic [WORD_W-1:0] acc_word_o
);
  localparam int CNT_W = $clog2(MATCH_N + ACK_N + 1);

  neg_state_e        st_q;
  logic [CNT_W-1:0]  hit_q, ackc_q;
  logic [WORD_W-1:0] cand_q, acc_q;
  logic [TMO_W-1:0]  idle_q;

  logic ok, same_cand, same_acc, tmo_hit;
  assign ok        = word_ok(rx_word_i, sgmii_i);
  assign same_cand = (rx_word_i & ~ACK_MASK) == (cand_q & ~ACK_MASK);
  assign same_acc  = (rx_word_i & ~ACK_MASK) == acc_q;
  assign tmo_hit   = !rx_valid_i && (timeout_i != '0) && (idle_q == timeout_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      hit_q  <= '0;
      ackc_q <= '0;
      cand_q <= '0;
      acc_q  <= '0;
      idle_q <= '0;
    end else begin
      idle_q <= (rx_valid_i || tmo_hit) ? '0 : idle_q + 1'b1;
      if (restart_i || tmo_hit) begin
        st_q   <= ST_HUNT;
        hit_q  <= '0;
        ackc_q <= '0;
        acc_q  <= '0;
      end else if (rx_valid_i) begin
        unique case (st_q)
          ST_HUNT: begin
            if (!ok) begin
              hit_q <= '0;
            end else if (hit_q != '0 && same_cand) begin
              if (hit_q == CNT_W'(MATCH_N - 1)) begin
                st_q   <= ST_ACKING;
                acc_q  <= rx_word_i & ~ACK_MASK;
                ackc_q <= '0;
                hit_q  <= '0;
              end else begin
                hit_q <= hit_q + 1'b1;
              end
            end else begin
              cand_q <= rx_word_i;
              hit_q  <= CNT_W'(1);
            end
          end
          ST_ACKING: begin
            if (!ok || !same_acc) begin
              st_q   <= ST_HUNT;
              hit_q  <= '0;
              ackc_q <= '0;
              acc_q  <= '0;
            end else if (rx_word_i[ACK_BIT]) begin
              if (ackc_q == CNT_W'(ACK_N - 1)) st_q <= ST_DONE;
              else ackc_q <= ackc_q + 1'b1;
            end else begin
              ackc_q <= '0;
            end
          end
          default: begin
            if (!ok || !same_acc) begin
              st_q   <= ST_HUNT;
              hit_q  <= '0;
              ackc_q <= '0;
              acc_q  <= '0;
            end
          end
        endcase
      end
    end
  end

  assign state_o    = st_q;
  assign acc_word_o = acc_q;

  // R9: acceptance only from hunting on a strobed word
  a_r9_accept_from_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACKING && $past(st_q) != ST_ACKING) |-> ($past(st_q) == ST_HUNT && $past(rx_valid_i)));
  // R10: completion needs an acknowledged word
  a_r10_done_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && $past(st_q) != ST_DONE) |-> ($past(st_q) == ST_ACKING && $past(rx_word_i[ACK_BIT])));
  // R12: a bad word after acceptance restarts
  a_r12_bad_word_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_HUNT && rx_valid_i && !ok) |=> st_q == ST_HUNT);
  // R13: timeout restarts
  a_r13_timeout_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |=> st_q == ST_HUNT);
endmodule

// File: rtl/icw_tx_enc.sv
module icw_tx_enc
  import icw_pkg::*;
(
  input  ctrl_t             ctrl_i,
  input  logic [WORD_W-1:0] adv_i,
  input  logic              loc_link_i,
  input  logic              loc_duplex_i,
  input  logic [1:0]        loc_speed_i,
  input  logic              ack_i,
  output logic [WORD_W-1:0] tx_word_o
);
  always_comb begin
    if (!ctrl_i.sgmii) begin
      tx_word_o          = adv_i;
      tx_word_o[ACK_BIT] = ack_i;
    end else if (ctrl_i.phy_side) begin
      tx_word_o = {loc_link_i, ack_i, 1'b0, loc_duplex_i, loc_speed_i, 9'b0, 1'b1};
    end else begin
      tx_word_o = {1'b0, ack_i, 13'b0, 1'b1};
    end
  end
endmodule

// File: rtl/icw_resolve.sv
module icw_resolve
  import icw_pkg::*;
(
  input  ctrl_t             ctrl_i,
  input  logic [WORD_W-1:0] adv_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              done_i,
  input  logic              loc_link_i,
  input  logic              loc_duplex_i,
  input  logic [1:0]        loc_speed_i,
  output logic              link_o,
  output logic [1:0]        speed_o,
  output logic              duplex_o
);
  always_comb begin
    if (!ctrl_i.sgmii) begin
      link_o   = done_i;
      speed_o  = 2'b10;
      duplex_o = done_i && adv_i[5] && acc_i[5];
    end else if (ctrl_i.phy_side) begin
      link_o   = done_i && loc_link_i;
      speed_o  = loc_speed_i;
      duplex_o = loc_duplex_i;
    end else begin
      link_o   = done_i && acc_i[15];
      speed_o  = (ctrl_i.spd_follow && done_i) ? acc_i[11:10] : ctrl_i.speed;
      duplex_o = done_i ? acc_i[12] : ctrl_i.duplex;
    end
  end
endmodule

// File: rtl/icw_top.sv
module icw_top
  import icw_pkg::*;
#(
  parameter int MATCH_N = 3,
  parameter int ACK_N   = 3,
  parameter int TMO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              adv_we_i,
  input  logic [WORD_W-1:0] adv_wdata_i,
  input  logic              hw_link_i,
  input  logic              hw_duplex_i,
  input  logic [1:0]        hw_speed_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              link_o,
  output logic [1:0]        speed_o,
  output logic              duplex_o,
  output logic              an_done_o
);
  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] adv_q, acc_w;
  neg_state_e        st_w;
  logic              loc_link, loc_duplex, done;
  logic [1:0]        loc_speed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      adv_q  <= ADV_RST;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
      if (adv_we_i)  adv_q  <= adv_wdata_i;
    end
  end

  assign loc_link   = ctrl_q.hw_sel ? hw_link_i   : ctrl_q.link;
  assign loc_duplex = ctrl_q.hw_sel ? hw_duplex_i : ctrl_q.duplex;
  assign loc_speed  = ctrl_q.hw_sel ? hw_speed_i  : ctrl_q.speed;

  icw_rx_track #(.MATCH_N(MATCH_N), .ACK_N(ACK_N), .TMO_W(TMO_W)) u_track (
    .clk_i, .rst_ni,
    .restart_i  (ctrl_we_i),
    .sgmii_i    (ctrl_q.sgmii),
    .rx_word_i, .rx_valid_i, .timeout_i,
    .state_o    (st_w),
    .acc_word_o (acc_w)
  );

  assign done = (st_w == ST_DONE);

  icw_tx_enc u_enc (
    .ctrl_i       (ctrl_q),
    .adv_i        (adv_q),
    .loc_link_i   (loc_link),
    .loc_duplex_i (loc_duplex),
    .loc_speed_i  (loc_speed),
    .ack_i        (st_w != ST_HUNT),
    .tx_word_o
  );

  icw_resolve u_res (
    .ctrl_i       (ctrl_q),
    .adv_i        (adv_q),
    .acc_i        (acc_w),
    .done_i       (done),
    .loc_link_i   (loc_link),
    .loc_duplex_i (loc_duplex),
    .loc_speed_i  (loc_speed),
    .link_o, .speed_o, .duplex_o
  );

  assign an_done_o = done;

  // R2: every SGMII word ends in a one
  a_r2_sgmii_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.sgmii |-> tx_word_o[0]);
  // R6: 1000BASE-X speed pinned at 1000
  a_r6_x_speed_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.sgmii |-> speed_o == 2'b10);
  // R10: a completed exchange keeps acknowledging
  a_r10_done_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_done_o |-> tx_word_o[ACK_BIT]);
  // R12: no link without completion
  a_r12_link_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> an_done_o);
  // R14: a control write drops completion
  a_r14_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !an_done_o);
endmodule

// File: tb/icw_top_tb_top.sv
`timescale 1ns/1ps
module icw_top_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        ctrl_we = 0, adv_we = 0;
  logic [8:0]  ctrl_wd = '0;
  logic [15:0] adv_wd = '0, rx_word = '0, timeout = '0;
  logic        hw_link = 0, hw_dup = 0, rx_valid = 0;
  logic [1:0]  hw_spd = '0;
  logic [15:0] tx_word;
  logic        link, duplex, done;
  logic [1:0]  speed;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  icw_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .adv_we_i(adv_we), .adv_wdata_i(adv_wd), .hw_link_i(hw_link), .hw_duplex_i(hw_dup),
    .hw_speed_i(hw_spd), .rx_word_i(rx_word), .rx_valid_i(rx_valid), .timeout_i(timeout),
    .tx_word_o(tx_word), .link_o(link), .speed_o(speed), .duplex_o(duplex), .an_done_o(done)
  );

  function automatic logic [15:0] exp_phy(input logic l, input logic a, input logic d, input logic [1:0] s);
    return {l, a, 1'b0, d, s, 9'b0, 1'b1};
  endfunction

  function automatic logic [15:0] exp_x(input logic [15:0] adv, input logic a);
    return (adv & 16'hBFFF) | {1'b0, a, 14'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w, input logic v);
    @(negedge clk); rx_valid = v; rx_word = w;
    @(posedge clk); #1;
  endtask

  task automatic wr_ctrl(input logic [8:0] d);
    @(negedge clk); rx_valid = 0; ctrl_we = 1; ctrl_wd = d;
    @(posedge clk); #1; ctrl_we = 0;
  endtask

  task automatic wr_adv(input logic [15:0] d);
    @(negedge clk); rx_valid = 0; adv_we = 1; adv_wd = d;
    @(posedge clk); #1; adv_we = 0;
  endtask

  task automatic negotiate(input logic [15:0] w);
    for (int i = 0; i < 3; i++) put(w & 16'hBFFF, 1'b1);
    for (int i = 0; i < 3; i++) put(w | 16'h4000, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1CF0));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 tx", tx_word, 16'h0001);
    chk("R1 done", done, 0);
    chk("R1 link", link, 0);

    // MAC side, acceptance and completion
    put(16'h9401, 1); put(16'h9401, 1);
    chk("R9 two words", tx_word, 16'h0001);
    put(16'h9401, 1);
    chk("R4 R9 accepted", tx_word, 16'h4001);
    put(16'hD401, 1); put(16'hD401, 1);
    chk("R10 two acks", done, 0);
    put(16'hD401, 1);
    chk("R10 done", done, 1);
    chk("R5 link", link, 1);
    chk("R5 duplex", duplex, 1);
    chk("R5 speed reg", speed, 2'b00);
    wr_ctrl(9'h104);
    chk("R14 restart", done, 0);
    negotiate(16'h9401);
    chk("R5 speed follow", speed, 2'b01);
    put(16'h9801, 1);
    chk("R12 done", done, 0);
    chk("R12 link", link, 0);
    chk("R12 tx", tx_word, 16'h0001);

    // validity
    put(16'h9401, 1); put(16'h9401, 1); put(16'h9C01, 1);
    put(16'h9401, 1); put(16'h9401, 1);
    chk("R11 reserved speed", tx_word, 16'h0001);
    put(16'h9401, 1);
    chk("R11 recount", tx_word, 16'h4001);
    wr_ctrl(9'h104);
    put(16'h9401, 1); put(16'h9401, 1); put(16'h9400, 1);
    put(16'h9401, 1); put(16'h9401, 1);
    chk("R11 bit0 clear", tx_word, 16'h0001);

    // timeout
    timeout = 16'd8;
    wr_ctrl(9'h104);
    negotiate(16'h9401);
    for (int i = 0; i < 7; i++) put(16'h0, 0);
    chk("R13 before limit", done, 1);
    put(16'h0, 0);
    chk("R13 at limit", done, 0);
    timeout = 16'd0;
    negotiate(16'h9401);
    for (int i = 0; i < 20; i++) put(16'h0, 0);
    chk("R13 disabled", done, 1);

    // PHY side
    wr_ctrl(9'h0BC);
    chk("R2 R3 reg word", tx_word, exp_phy(1, 0, 1, 2'b10));
    for (int i = 0; i < 3; i++) put(16'h0001, 1);
    chk("R2 ack", tx_word, exp_phy(1, 1, 1, 2'b10));
    for (int i = 0; i < 3; i++) put(16'h4001, 1);
    chk("R10 phy done", done, 1);
    chk("R2 phy link", link, 1);
    for (int i = 0; i < 16; i++) begin
      logic [8:0] c;
      c = 9'($urandom()) | 9'h00C;
      c[8] = 1'b0;
      hw_link = 1'($urandom()); hw_dup = 1'($urandom()); hw_spd = 2'($urandom());
      wr_ctrl(c);
      if (c[0]) chk("R3 pins", tx_word, exp_phy(hw_link, 0, hw_dup, hw_spd));
      else      chk("R3 fields", tx_word, exp_phy(c[4], 0, c[5], c[7:6]));
    end

    // 1000BASE-X
    wr_ctrl(9'h018);
    chk("R8 x speed", speed, 2'b10);
    chk("R1 R7 adv reset", tx_word, 16'h0020);
    wr_adv(16'h01A0);
    chk("R7 adv write", tx_word, 16'h01A0);
    wr_ctrl(9'h158);
    chk("R6 follow ignored", speed, 2'b10);
    negotiate(16'h01A0);
    chk("R7 ack word", tx_word, 16'h41A0);
    chk("R6 x duplex", duplex, 1);
    chk("R10 x done", done, 1);
    for (int i = 0; i < 12; i++) begin
      logic [15:0] a, w;
      a = 16'($urandom()); w = 16'($urandom()) & 16'hBFFF;
      wr_adv(a);
      wr_ctrl(9'h018 | (9'($urandom()) & 9'h1C0));
      negotiate(w);
      chk("R7 rand tx", tx_word, exp_x(a, 1));
      chk("R6 rand duplex", duplex, a[5] & w[5]);
      chk("R6 rand speed", speed, 2'b10);
      chk("R10 rand done", done, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule